// File: doc/BRIEF.md
# Codec Data Clock and Serial Port Controller

This block sits between a delta-modulation voice codec core and its serial pins. It either produces the encoder and decoder data clocks by dividing the master clock, or it takes both clocks from outside. A two-bit mode input selects the source. In the divided modes the clock ports are driven as outputs at a 50% duty cycle, so that surrounding logic can lock to the codec bit rate. In external mode the ports become inputs, and the encoder and decoder may run from two unrelated clocks.

Whatever the source, the core receives a one-cycle strobe in the master-clock domain at each rising data-clock edge. The decoder's serial input bit is captured on that strobe. The encoder serial pin has three states, set by an enable input and an active-low powersave input: driven with data, released to high impedance for sharing a line, or held low.

Top module: `dclk_port_ctrl`

## Requirements
- R1: While reset is held (synchronous, active high) and in the first cycle after it, both clock outputs are 0, both strobes are 0 and the captured decoder bit is 0.
- R2: With the active mode 00 (external), clk_port_oe is 0 and both clock outputs stay 0.
- R3: Mode 01, 10 and 11 divide the master clock by 16, 32 and 64. The clock is the same on both ports, clk_port_oe is 1, and after reset or a mode adoption the clock is low for the first half period and high for the second.
- R4: In a divided mode, enc_strobe and dec_strobe are both high for exactly the one cycle in which the clock output is first seen high.
- R5: In external mode, each strobe follows only its own clock pin. The strobe is high for one cycle, in the cycle after the second rising master-clock edge that samples the pin high after it was low. The other strobe is unaffected.
- R6: dec_bit takes the value that dec_data_in had two master-clock edges before the edge ending a dec_strobe cycle, and holds it at all other times.
- R7: A new mode value is adopted only on an edge at which the divided clock is low, and the divider then restarts. A high phase is therefore never shortened: a change requested while the clock is high lets that phase run to its full length.
- R8: With psave_n = 1 and data_en = 1, ser_oe is 1 and ser_out follows enc_bit.
- R9: With psave_n = 1 and data_en = 0, ser_oe is 0 (high impedance) and ser_out is 0.
- R10: With psave_n = 0, ser_oe is 1 and ser_out is 0, whatever data_en is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Clock source: 00 external, 01/10/11 divide by 16/32/64 |
| enc_clk_in | input | 1 | Encoder clock pin value, used in external mode |
| dec_clk_in | input | 1 | Decoder clock pin value, used in external mode |
| enc_clk_out | output | 1 | Divided clock for the encoder clock pin |
| dec_clk_out | output | 1 | Divided clock for the decoder clock pin |
| clk_port_oe | output | 1 | Drive enable for both clock pins |
| enc_strobe | output | 1 | One-cycle encoder data-clock edge marker |
| dec_strobe | output | 1 | One-cycle decoder data-clock edge marker |
| dec_data_in | input | 1 | Decoder serial data pin |
| dec_bit | output | 1 | Last captured decoder bit |
| enc_bit | input | 1 | Encoder bit from the codec core |
| data_en | input | 1 | Encoder output enable |
| psave_n | input | 1 | Powersave, active low |
| ser_out | output | 1 | Encoder serial pin value |
| ser_oe | output | 1 | Encoder serial pin drive enable |

## Verification
A wrong divider count or duty error shows on the clock ports within one period, at most 64 cycles. A mode adopted while the clock is high shows as a shortened high phase in the first period after the change. A faulty synchroniser or edge detector moves or doubles a strobe relative to its clock pin at the first external edge, which is two cycles later. A bad capture shows on dec_bit one cycle after the strobe. The serial pin state is combinational, so a wrong enable decode is visible in the same cycle.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    localparam int BASE_LOG2 = 4;

    typedef enum logic [1:0] {
        CLK_EXT   = 2'b00,
        CLK_DIV_A = 2'b01,
        CLK_DIV_B = 2'b10,
        CLK_DIV_C = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        PORT_DRIVE,
        PORT_HIZ,
        PORT_LOW
    } port_state_e;

    typedef struct packed {
        logic enc;
        logic dec;
    } strobe_t;

    function automatic int unsigned half_len(clk_mode_e m, int unsigned base_log2);
        if (m == CLK_EXT) return 0;
        return 32'd1 << (base_log2 - 1 + int'(m) - 1);
    endfunction

endpackage

// File: rtl/dclk_divider.sv
module dclk_divider
    import dclk_pkg::*;
#(
    parameter int BASE_LOG2 = dclk_pkg::BASE_LOG2,
    localparam int CNT_W = BASE_LOG2 + 2
) (
    input  logic      clk,
    input  logic      rst,
    input  clk_mode_e mode_req,
    output clk_mode_e mode_act,
    output logic      div_clk,
    output logic      div_rise
);

    logic [CNT_W-1:0] cnt, cnt_nx, half_v, last_v;
    logic             div_clk_d;
    logic [CNT_W-1:0] hi_run;

    assign half_v = CNT_W'(half_len(mode_act, BASE_LOG2));
    assign last_v = CNT_W'(2 * half_len(mode_act, BASE_LOG2) - 1);
    assign cnt_nx = (cnt == last_v) ? '0 : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_act  <= mode_req;
            cnt       <= '0;
            div_clk   <= 1'b0;
            div_clk_d <= 1'b0;
        end else begin
            div_clk_d <= div_clk;
            if (mode_req != mode_act && !div_clk) begin
                mode_act <= mode_req;
                cnt      <= '0;
                div_clk  <= 1'b0;
            end else if (mode_act == CLK_EXT) begin
                cnt     <= '0;
                div_clk <= 1'b0;
            end else begin
                cnt     <= cnt_nx;
                div_clk <= (cnt_nx >= half_v);
            end
        end
    end

    assign div_rise = div_clk & ~div_clk_d;

    // Length of the current high phase, for the checks below
    always_ff @(posedge clk) begin
        if (rst)          hi_run <= '0;
        else if (div_clk) hi_run <= hi_run + 1'b1;
        else              hi_run <= '0;
    end

    assert_rise_single_R4: assert property (@(posedge clk) disable iff (rst)
        div_rise |=> !div_rise);

    assert_switch_low_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_act != $past(mode_act)) |-> !$past(div_clk));

    assert_full_high_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(div_clk) |-> (hi_run == half_v));

endmodule

// File: rtl/dclk_sync.sv
module dclk_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl
);

    logic [STAGES-1:0][WIDTH-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], din};
    end

    assign lvl = sh[STAGES-1];

endmodule

// File: rtl/dclk_edge.sv
module dclk_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_ch
        assign rise[g] = lvl[g] & ~prev[g];

        assert_edge_single_R5: assert property (@(posedge clk) disable iff (rst)
            rise[g] |=> !rise[g]);
    end

endmodule

// File: rtl/dclk_out_ctrl.sv
module dclk_out_ctrl
    import dclk_pkg::*;
(
    input  logic data_en,
    input  logic psave_n,
    input  logic enc_bit,
    output logic ser_out,
    output logic ser_oe
);

    port_state_e st;

    always_comb begin
        if (!psave_n)     st = PORT_LOW;
        else if (data_en) st = PORT_DRIVE;
        else              st = PORT_HIZ;
    end

    always_comb begin
        unique case (st)
            PORT_DRIVE: begin ser_oe = 1'b1; ser_out = enc_bit; end
            PORT_LOW:   begin ser_oe = 1'b1; ser_out = 1'b0;    end
            default:    begin ser_oe = 1'b0; ser_out = 1'b0;    end
        endcase
    end

endmodule

// File: rtl/dclk_port_ctrl.sv
module dclk_port_ctrl
    import dclk_pkg::*;
#(
    parameter int BASE_LOG2   = dclk_pkg::BASE_LOG2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       enc_clk_in,
    input  logic       dec_clk_in,
    output logic       enc_clk_out,
    output logic       dec_clk_out,
    output logic       clk_port_oe,
    output logic       enc_strobe,
    output logic       dec_strobe,
    input  logic       dec_data_in,
    output logic       dec_bit,
    input  logic       enc_bit,
    input  logic       data_en,
    input  logic       psave_n,
    output logic       ser_out,
    output logic       ser_oe
);

    clk_mode_e  mode_req, mode_act;
    logic       div_clk, div_rise;
    logic [1:0] ext_lvl, ext_rise;
    logic       data_lvl;
    strobe_t    stb;

    assign mode_req = clk_mode_e'(mode_sel);

    dclk_divider #(.BASE_LOG2(BASE_LOG2)) u_div (
        .clk(clk), .rst(rst), .mode_req(mode_req),
        .mode_act(mode_act), .div_clk(div_clk), .div_rise(div_rise)
    );

    dclk_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_clk_sync (
        .clk(clk), .rst(rst), .din({dec_clk_in, enc_clk_in}), .lvl(ext_lvl)
    );

    dclk_edge #(.WIDTH(2)) u_clk_edge (
        .clk(clk), .rst(rst), .lvl(ext_lvl), .rise(ext_rise)
    );

    dclk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_data_sync (
        .clk(clk), .rst(rst), .din(dec_data_in), .lvl(data_lvl)
    );

    dclk_out_ctrl u_out (
        .data_en(data_en), .psave_n(psave_n), .enc_bit(enc_bit),
        .ser_out(ser_out), .ser_oe(ser_oe)
    );

    always_comb begin
        if (mode_act == CLK_EXT) begin
            stb.enc = ext_rise[0];
            stb.dec = ext_rise[1];
        end else begin
            stb.enc = div_rise;
            stb.dec = div_rise;
        end
    end

    assign clk_port_oe = (mode_act != CLK_EXT);
    assign enc_clk_out = div_clk;
    assign dec_clk_out = div_clk;
    assign enc_strobe  = stb.enc;
    assign dec_strobe  = stb.dec;

    always_ff @(posedge clk) begin
        if (rst)          dec_bit <= 1'b0;
        else if (stb.dec) dec_bit <= data_lvl;
    end

    assert_ext_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !clk_port_oe |-> (!enc_clk_out && !dec_clk_out));

    assert_shared_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        clk_port_oe |-> (enc_strobe == dec_strobe));

    assert_bit_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !dec_strobe |=> $stable(dec_bit));

    assert_lowpower_R10: assert property (@(posedge clk) disable iff (rst)
        !psave_n |-> (ser_oe && !ser_out));

endmodule

// File: tb/tb_dclk_port_ctrl.sv
module tb_dclk_port_ctrl;

    localparam int CLK_T = 10;

    logic clk = 1'b0;
    logic rst;
    logic [1:0] mode_sel;
    logic enc_clk_in, dec_clk_in, dec_data_in, enc_bit, data_en, psave_n;
    logic enc_clk_out, dec_clk_out, clk_port_oe, enc_strobe, dec_strobe;
    logic dec_bit, ser_out, ser_oe;

    always #(CLK_T/2) clk = ~clk;

    dclk_port_ctrl dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .enc_clk_in(enc_clk_in), .dec_clk_in(dec_clk_in),
        .enc_clk_out(enc_clk_out), .dec_clk_out(dec_clk_out),
        .clk_port_oe(clk_port_oe), .enc_strobe(enc_strobe), .dec_strobe(dec_strobe),
        .dec_data_in(dec_data_in), .dec_bit(dec_bit), .enc_bit(enc_bit),
        .data_en(data_en), .psave_n(psave_n), .ser_out(ser_out), .ser_oe(ser_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(string req, int got, int exp, string what);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got=%0d exp=%0d at %0t", req, what, got, exp, $time);
        end
    endtask

    function automatic int bhalf(int m);
        return (m == 0) ? 0 : (8 << (m - 1));
    endfunction

    // Expected behaviour, built from R1..R7
    int m_mode, m_k, h;
    bit m_clk, m_prev, m_enc_stb, m_dec_stb, m_dec, m_in_rst;
    bit ec1, ec2, ec3, dc1, dc2, dc3, dd1, dd2;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = int'(mode_sel); m_k = 0; m_clk = 0; m_prev = 0; m_dec = 0;
            ec1 = 0; ec2 = 0; ec3 = 0; dc1 = 0; dc2 = 0; dc3 = 0; dd1 = 0; dd2 = 0;
            m_in_rst = 1;
        end else begin
            m_in_rst = 0;
            if (m_dec_stb) m_dec = dd2;
            m_prev = m_clk;
            if (int'(mode_sel) != m_mode && !m_clk) begin
                m_mode = int'(mode_sel); m_k = 0; m_clk = 0;
            end else if (m_mode == 0) begin
                m_k = 0; m_clk = 0;
            end else begin
                h = bhalf(m_mode);
                m_k = (m_k + 1) % (2 * h);
                m_clk = (m_k >= h);
            end
            ec3 = ec2; ec2 = ec1; ec1 = enc_clk_in;
            dc3 = dc2; dc2 = dc1; dc1 = dec_clk_in;
            dd2 = dd1; dd1 = dec_data_in;
        end
        if (m_mode != 0) begin
            m_enc_stb = m_clk && !m_prev;
            m_dec_stb = m_enc_stb;
        end else begin
            m_enc_stb = ec2 && !ec3;
            m_dec_stb = dc2 && !dc3;
        end
    end

    always @(posedge clk) begin
        #(CLK_T/4);
        if (!done) begin
            string rc, rs;
            rc = m_in_rst ? "R1" : ((m_mode == 0) ? "R2" : "R3");
            rs = m_in_rst ? "R1" : ((m_mode == 0) ? "R5" : "R4");
            chk(rc, int'(clk_port_oe), int'(m_mode != 0), "clk_port_oe");
            chk(rc, int'(enc_clk_out), int'(m_clk), "enc_clk_out");
            chk(rc, int'(dec_clk_out), int'(m_clk), "dec_clk_out");
            chk(rs, int'(enc_strobe), int'(m_enc_stb), "enc_strobe");
            chk(rs, int'(dec_strobe), int'(m_dec_stb), "dec_strobe");
            chk(m_in_rst ? "R1" : "R6", int'(dec_bit), int'(m_dec), "dec_bit");
            if (!psave_n) begin
                chk("R10", int'(ser_oe), 1, "ser_oe");
                chk("R10", int'(ser_out), 0, "ser_out");
            end else if (data_en) begin
                chk("R8", int'(ser_oe), 1, "ser_oe");
                chk("R8", int'(ser_out), int'(enc_bit), "ser_out");
            end else begin
                chk("R9", int'(ser_oe), 0, "ser_oe");
                chk("R9", int'(ser_out), 0, "ser_out");
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_T * 200000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R1 watchdog got=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int hi, lo, ecnt, dcnt;
        void'($urandom(32'd2024));
        rst = 1'b1; mode_sel = 2'b11;
        enc_clk_in = 0; dec_clk_in = 0; dec_data_in = 0;
        enc_bit = 0; data_en = 1; psave_n = 1;
        repeat (4) @(negedge clk);
        chk("R1", int'(enc_clk_out), 0, "reset clk");
        chk("R1", int'(enc_strobe | dec_strobe), 0, "reset strobes");
        chk("R1", int'(dec_bit), 0, "reset dec_bit");
        rst = 1'b0;

        // R7: request divide-by-16 while the divide-by-64 clock is high
        while (!enc_clk_out) @(negedge clk);
        mode_sel = 2'b01;
        hi = 1;
        @(negedge clk);
        while (enc_clk_out) begin hi++; @(negedge clk); end
        chk("R7", hi, 32, "high run at change");
        lo = 0;
        while (!enc_clk_out) begin lo++; @(negedge clk); end
        chk("R7", lo, 9, "low run after adoption");
        hi = 0;
        while (enc_clk_out) begin hi++; @(negedge clk); end
        chk("R3", hi, 8, "high run div16");

        // R5: external encoder edge, decoder untouched
        mode_sel = 2'b00;
        repeat (80) @(negedge clk);
        enc_clk_in = 1'b1;
        @(negedge clk);
        chk("R5", int'(enc_strobe), 0, "enc strobe after 1 edge");
        @(negedge clk);
        chk("R5", int'(enc_strobe), 1, "enc strobe after 2 edges");
        chk("R5", int'(dec_strobe), 0, "dec strobe independent");
        @(negedge clk);
        chk("R5", int'(enc_strobe), 0, "enc strobe one cycle");
        enc_clk_in = 1'b0;

        // Random phases of mode, pin clocks, data and port controls
        ecnt = 3; dcnt = 5;
        for (int p = 0; p < 40; p++) begin
            int len;
            mode_sel = 2'($urandom_range(0, 3));
            len = int'($urandom_range(100, 400));
            if (p == 20) rst = 1'b1;
            for (int c = 0; c < len; c++) begin
                @(negedge clk);
                if (p == 20 && c == 3) rst = 1'b0;
                if (--ecnt == 0) begin enc_clk_in = ~enc_clk_in; ecnt = int'($urandom_range(3, 9)); end
                if (--dcnt == 0) begin dec_clk_in = ~dec_clk_in; dcnt = int'($urandom_range(3, 9)); end
                if ($urandom_range(0, 3) == 0) dec_data_in = 1'($urandom);
                enc_bit = 1'($urandom);
                data_en = ($urandom_range(0, 3) != 0);
                psave_n = ($urandom_range(0, 4) != 0);
            end
        end

        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule